// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between the execute stage of a 32-bit RISC core and a 32-bit memory bus that numbers its bytes big-endian. For each access it forms the effective address from a base register and a signed 16-bit displacement taken from the instruction word. Stores take the displacement from two split instruction fields. Loads take it from the low sixteen bits.

On a store the block places the source data in the byte lanes that the address and access size select. It drives a 4-bit write-enable with one bit per byte, bit 3 covering the most significant byte. On a load it raises a read strobe, takes the returned word one cycle later and picks out the addressed byte or halfword, then sign- or zero-extends it.

Accesses that are not naturally aligned are refused. A refused store writes nothing and raises a store fault. A refused load issues no read and reports a fault together with its result, so the register write-back can be cancelled. The request stage and the result stage are both registered, which gives a fixed two-cycle load latency.

Top module: `be_lsu`

## Requirements
- R1: The effective address is `base_val` plus the sign-extended 16-bit displacement. For loads the displacement is `insn[15:0]`. For stores it is `{insn[25:21], insn[10:0]}`, and `insn[20:11]` is ignored. `bus_addr` shows this address one clock after the request.
- R2: A byte store (`req_size`=00) at address offset k (address bits 1:0) drives mask bit 3-k alone. It places `store_val[7:0]` in bits [31-8k:24-8k]: offset 0→mask 8, 1→4, 2→2, 3→1.
- R3: A halfword store (`req_size`=01) at offset 0 drives mask C with `store_val[15:0]` in bits 31:16. At offset 2 it drives mask 3 with the halfword in bits 15:0.
- R4: A word store (`req_size`=10) at offset 0 drives mask F with `store_val` unchanged.
- R5: A halfword store at an odd offset, a word store at a nonzero offset, or any request with `req_size`=11 raises `st_fault` one clock after the request, with a zero mask and zero write data. The memory word is left unchanged.
- R6: A byte load returns the lane picked by the offset in the same big-endian order. It is sign-extended when `req_signed`=1 and zero-extended otherwise. `ld_valid` and `ld_data` appear two clocks after the request.
- R7: A halfword load returns bits 31:16 at offset 0 and bits 15:0 at offset 2, extended as in R6.
- R8: A word load at offset 0 returns the full read word in both the signed and the unsigned form.
- R9: A misaligned load (the same rules as R5) does not raise `bus_rd`. Two clocks after the request it gives `ld_valid`=1, `ld_fault`=1 and `ld_data`=0.
- R10: Write-data bytes outside the mask are zero, and `bus_rd` is never high while the mask is nonzero. Every `bus_rd` is followed on the next clock by a fault-free `ld_valid`.
- R11: While `rst` is high on a clock edge, every output is cleared to zero.
- R12: A cycle with `req_valid`=0 produces no write mask, no read strobe, no `st_fault` and, one clock later, no `ld_valid`, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| base_val | input | 32 | Base register value |
| store_val | input | 32 | Store source register value |
| insn | input | 32 | Instruction word holding the displacement |
| bus_rdata | input | 32 | Read word returned by memory in the cycle after `bus_rd` |
| bus_addr | output | 32 | Registered effective byte address |
| bus_wmask | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| bus_wdata | output | 32 | Lane-positioned write data |
| bus_rd | output | 1 | Read strobe for an aligned load |
| st_fault | output | 1 | Misaligned or reserved-size store refused |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |
| ld_fault | output | 1 | The load result belongs to a refused access |

## Verification
A wrong lane choice shows up at the write mask and write data in the clock right after the store request. It also shows up two clocks later as a corrupted word when the same address is read back through the bench memory, which merges writes by mask. A stale offset, size or sign held in the load stage shows as a wrong byte or wrong extension on `ld_data` exactly two clocks after the request. A lost alignment decision shows as a missing or spurious fault in the same cycles. A write that should have been suppressed shows on a later read of the untouched word.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/be_lsu_agen.sv
// Effective address: base + sign-extended displacement, split field for stores.
module be_lsu_agen #(
  parameter int ADDR_W   = 32,
  parameter int INSN_W   = 32,
  parameter int IMM_W    = 16,
  parameter int HI_W     = 5,
  parameter int HI_POS   = 21
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [INSN_W-1:0] insn,
  input  logic              is_store,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int LO_W = IMM_W - HI_W;

  logic [IMM_W-1:0] disp;

  always_comb begin
    if (is_store) disp = {insn[HI_POS+HI_W-1:HI_POS], insn[LO_W-1:0]};
    else          disp = insn[IMM_W-1:0];
  end

  assign eff_addr = base + {{(ADDR_W-IMM_W){disp[IMM_W-1]}}, disp};
endmodule

// File: rtl/be_lsu_lane_sel.sv
// Alignment check and per-lane enables; lane 0 is the most significant byte.
module be_lsu_lane_sel
  import be_lsu_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misalign,
  output logic [LANES-1:0] lane_en
);
  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ofs[0];
      SZ_WORD: misalign = |ofs;
      default: misalign = 1'b1;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = !misalign &&
      ((size == SZ_BYTE && ofs == OFS_W'(i)) ||
       (size == SZ_HALF && (ofs >> 1) == OFS_W'(i / 2)) ||
       (size == SZ_WORD));
  end
endmodule

// File: rtl/be_lsu_st_pack.sv
// Places store data on the enabled lanes, zero elsewhere.
module be_lsu_st_pack
  import be_lsu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8
) (
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] src,
  input  logic [LANES-1:0]  lane_en,
  output logic [LANES-1:0]  wmask,
  output logic [DATA_W-1:0] wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] pick;
    always_comb begin
      unique case (size)
        SZ_BYTE: pick = src[7:0];
        SZ_HALF: pick = (i % 2 == 0) ? src[15:8] : src[7:0];
        default: pick = src[DATA_W-1-8*i -: 8];
      endcase
    end
    assign wmask[LANES-1-i]          = lane_en[i];
    assign wdata[DATA_W-1-8*i -: 8] = lane_en[i] ? pick : 8'h00;
  end
endmodule

// File: rtl/be_lsu_ld_ext.sv
// Picks the addressed byte or halfword from a big-endian word and extends it.
module be_lsu_ld_ext
  import be_lsu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rword,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] aligned;

  assign aligned = rword << {ofs, 3'b000};

  always_comb begin
    unique case (size)
      SZ_BYTE: value = {{(DATA_W-8){sign_ext & aligned[DATA_W-1]}},
                        aligned[DATA_W-1 -: 8]};
      SZ_HALF: value = {{(DATA_W-16){sign_ext & aligned[DATA_W-1]}},
                        aligned[DATA_W-1 -: 16]};
      default: value = rword;
    endcase
  end
endmodule

// File: rtl/be_lsu.sv
// Load/store lane unit: registered request stage, registered load result stage.
module be_lsu
  import be_lsu_pkg::*;
#(
  parameter  int DATA_W     = 32,
  parameter  int ADDR_W     = 32,
  parameter  int INSN_W     = 32,
  parameter  int IMM_W      = 16,
  parameter  int IMM_HI_W   = 5,
  parameter  int IMM_HI_POS = 21,
  localparam int LANES      = DATA_W / 8,
  localparam int OFS_W      = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DATA_W-1:0] store_val,
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_wmask,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              st_fault,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_fault
);
  acc_size_e         size_in;
  logic [ADDR_W-1:0] eff_addr;
  logic [OFS_W-1:0]  ofs_in;
  logic              misalign;
  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  pk_mask;
  logic [DATA_W-1:0] pk_data;

  // load stage bookkeeping
  logic              ld_pend;
  logic              ld_bad;
  logic [OFS_W-1:0]  ld_ofs;
  acc_size_e         ld_size;
  logic              ld_sign;
  logic [DATA_W-1:0] ext_value;

  assign size_in = acc_size_e'(req_size);
  assign ofs_in  = eff_addr[OFS_W-1:0];

  be_lsu_agen #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .IMM_W(IMM_W),
    .HI_W(IMM_HI_W), .HI_POS(IMM_HI_POS)
  ) u_agen (
    .base    (base_val),
    .insn    (insn),
    .is_store(req_store),
    .eff_addr(eff_addr)
  );

  be_lsu_lane_sel #(.LANES(LANES)) u_sel (
    .size    (size_in),
    .ofs     (ofs_in),
    .misalign(misalign),
    .lane_en (lane_en)
  );

  be_lsu_st_pack #(.DATA_W(DATA_W)) u_pack (
    .size   (size_in),
    .src    (store_val),
    .lane_en(lane_en),
    .wmask  (pk_mask),
    .wdata  (pk_data)
  );

  be_lsu_ld_ext #(.DATA_W(DATA_W)) u_ext (
    .rword   (bus_rdata),
    .ofs     (ld_ofs),
    .size    (ld_size),
    .sign_ext(ld_sign),
    .value   (ext_value)
  );

  // request stage
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_wmask <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      st_fault  <= 1'b0;
      ld_pend   <= 1'b0;
      ld_bad    <= 1'b0;
      ld_ofs    <= '0;
      ld_size   <= SZ_BYTE;
      ld_sign   <= 1'b0;
    end else begin
      if (req_valid) bus_addr <= eff_addr;
      bus_wmask <= (req_valid && req_store) ? pk_mask : '0;
      bus_wdata <= (req_valid && req_store) ? pk_data : '0;
      bus_rd    <= req_valid && !req_store && !misalign;
      st_fault  <= req_valid && req_store && misalign;
      ld_pend   <= req_valid && !req_store;
      ld_bad    <= misalign;
      ld_ofs    <= ofs_in;
      ld_size   <= size_in;
      ld_sign   <= req_signed;
    end
  end

  // result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_fault <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= ld_pend;
      ld_fault <= ld_pend && ld_bad;
      ld_data  <= (ld_pend && !ld_bad) ? ext_value : '0;
    end
  end
endmodule

// File: rtl/be_lsu_chk.sv
// Port-level properties of the lane unit, attached by bind.
module be_lsu_chk #(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_store,
  input logic [1:0]        req_size,
  input logic [LANES-1:0]  bus_wmask,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic              st_fault,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data,
  input logic              ld_fault
);
  logic [DATA_W-1:0] keep;
  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keep[DATA_W-1-8*i -: 8] = {8{bus_wmask[LANES-1-i]}};
  end

  // R2: a byte store enables exactly one lane
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_store && req_size == 2'b00) |-> $countones(bus_wmask) == 1);

  // R5: a refused store writes nothing
  p_fault_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    st_fault |-> (bus_wmask == '0 && bus_wdata == '0));

  // R9: a refused load carries a zero result
  p_ld_fault_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ld_fault |-> (ld_valid && ld_data == '0));

  // R10: no data outside the enabled lanes
  p_data_in_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wdata & ~keep) == '0);

  // R10: read and write never together
  p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && (bus_wmask != '0)));

  // R10: each read strobe yields a clean result next clock
  p_rd_gives_result_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (ld_valid && !ld_fault));

  // R12: an idle cycle drives nothing
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (bus_wmask == '0 && !bus_rd && !st_fault));
endmodule

bind be_lsu be_lsu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_store(req_store),
  .req_size (req_size),
  .bus_wmask(bus_wmask),
  .bus_wdata(bus_wdata),
  .bus_rd   (bus_rd),
  .st_fault (st_fault),
  .ld_valid (ld_valid),
  .ld_data  (ld_data),
  .ld_fault (ld_fault)
);

// File: tb/be_lsu_test.sv
module be_lsu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] store_val = '0;
  logic [31:0] insn = '0;
  logic [31:0] bus_rdata;
  logic [31:0] bus_addr;
  logic [3:0]  bus_wmask;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic        st_fault;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        ld_fault;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  be_lsu uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .base_val(base_val),
    .store_val(store_val), .insn(insn), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wmask(bus_wmask), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .st_fault(st_fault), .ld_valid(ld_valid),
    .ld_data(ld_data), .ld_fault(ld_fault)
  );

  // word memory model, merges writes by byte mask (bit 3 = bits 31:24)
  logic [31:0] mem [16];
  assign bus_rdata = mem[bus_addr[5:2]];
  always @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (bus_wmask[b]) mem[bus_addr[5:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // store: displacement split into insn[25:21] and insn[10:0]; insn[20:11] filled with junk
  task automatic store_op(input string tag, input logic [1:0] sz, input logic [31:0] base,
                          input logic [15:0] disp, input logic [31:0] val,
                          input logic [31:0] e_addr, input logic [3:0] e_mask,
                          input logic [31:0] e_data, input logic e_fault);
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b1; req_size = sz; req_signed = 1'b0;
    base_val = base; store_val = val;
    insn = {6'h35, disp[15:11], 5'h0a, 5'h1b, disp[10:0]};
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " addr"},  bus_addr, e_addr);
    check({tag, " mask"},  {28'h0, bus_wmask}, {28'h0, e_mask});
    check({tag, " wdata"}, bus_wdata, e_data);
    check({tag, " fault"}, {31'h0, st_fault}, {31'h0, e_fault});
    check({tag, " rd"},    {31'h0, bus_rd}, 32'h0);
  endtask

  task automatic load_op(input string tag, input logic [1:0] sz, input logic sgn,
                         input logic [31:0] base, input logic [15:0] disp,
                         input logic [31:0] e_addr, input logic [31:0] e_data,
                         input logic e_fault);
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = sz; req_signed = sgn;
    base_val = base; store_val = 32'hdead_beef;
    insn = {6'h21, 5'h1f, 5'h02, disp};
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " addr"}, bus_addr, e_addr);
    check({tag, " rd"},   {31'h0, bus_rd}, {31'h0, !e_fault});
    @(negedge clk);
    check({tag, " valid"}, {31'h0, ld_valid}, 32'h1);
    check({tag, " data"},  ld_data, e_data);
    check({tag, " fault"}, {31'h0, ld_fault}, {31'h0, e_fault});
  endtask

  task automatic t_reset;
    check("R11 addr",  bus_addr, 32'h0);
    check("R11 mask",  {28'h0, bus_wmask}, 32'h0);
    check("R11 wdata", bus_wdata, 32'h0);
    check("R11 flags", {28'h0, bus_rd, st_fault, ld_valid, ld_fault}, 32'h0);
    check("R11 data",  ld_data, 32'h0);
  endtask

  task automatic t_word_and_addr;
    store_op("R4 word store", 2'b10, 32'h100, 16'h0008, 32'h80f1_7f22,
             32'h108, 4'hf, 32'h80f1_7f22, 1'b0);
    // R1: negative displacement, high field all ones
    store_op("R1 neg disp store", 2'b10, 32'h120, 16'hfff0, 32'h1122_3344,
             32'h110, 4'hf, 32'h1122_3344, 1'b0);
    load_op("R1 neg disp load", 2'b10, 1'b0, 32'h118, 16'hfff8, 32'h110, 32'h1122_3344, 1'b0);
  endtask

  task automatic t_byte_loads;
    load_op("R6 byte0 signed",   2'b00, 1'b1, 32'h100, 16'h0008, 32'h108, 32'hffff_ff80, 1'b0);
    load_op("R6 byte0 unsigned", 2'b00, 1'b0, 32'h100, 16'h0008, 32'h108, 32'h0000_0080, 1'b0);
    load_op("R6 byte1 signed",   2'b00, 1'b1, 32'h100, 16'h0009, 32'h109, 32'hffff_fff1, 1'b0);
    load_op("R6 byte2 signed",   2'b00, 1'b1, 32'h100, 16'h000a, 32'h10a, 32'h0000_007f, 1'b0);
    load_op("R6 byte3 unsigned", 2'b00, 1'b0, 32'h100, 16'h000b, 32'h10b, 32'h0000_0022, 1'b0);
  endtask

  task automatic t_half_word_loads;
    load_op("R7 half0 signed",   2'b01, 1'b1, 32'h100, 16'h0008, 32'h108, 32'hffff_80f1, 1'b0);
    load_op("R7 half0 unsigned", 2'b01, 1'b0, 32'h100, 16'h0008, 32'h108, 32'h0000_80f1, 1'b0);
    load_op("R7 half2 signed",   2'b01, 1'b1, 32'h100, 16'h000a, 32'h10a, 32'h0000_7f22, 1'b0);
    load_op("R8 word signed",    2'b10, 1'b1, 32'h100, 16'h0008, 32'h108, 32'h80f1_7f22, 1'b0);
    load_op("R8 word unsigned",  2'b10, 1'b0, 32'h100, 16'h0008, 32'h108, 32'h80f1_7f22, 1'b0);
  endtask

  task automatic t_bad_loads;
    load_op("R9 half odd",   2'b01, 1'b1, 32'h100, 16'h0009, 32'h109, 32'h0, 1'b1);
    load_op("R9 word off2",  2'b10, 1'b0, 32'h100, 16'h000a, 32'h10a, 32'h0, 1'b1);
    load_op("R9 rsvd size",  2'b11, 1'b0, 32'h100, 16'h0008, 32'h108, 32'h0, 1'b1);
  endtask

  task automatic t_byte_stores;
    store_op("R2 byte off0", 2'b00, 32'h110, 16'h0000, 32'h1234_56aa, 32'h110, 4'h8, 32'haa00_0000, 1'b0);
    store_op("R2 byte off1", 2'b00, 32'h110, 16'h0001, 32'hffff_ffbb, 32'h111, 4'h4, 32'h00bb_0000, 1'b0);
    store_op("R2 byte off2", 2'b00, 32'h110, 16'h0002, 32'h0000_00cc, 32'h112, 4'h2, 32'h0000_cc00, 1'b0);
    store_op("R2 byte off3", 2'b00, 32'h110, 16'h0003, 32'h5555_55dd, 32'h113, 4'h1, 32'h0000_00dd, 1'b0);
    load_op("R2 merged word", 2'b10, 1'b0, 32'h110, 16'h0000, 32'h110, 32'haabb_ccdd, 1'b0);
  endtask

  task automatic t_half_stores;
    store_op("R3 seed word", 2'b10, 32'h114, 16'h0000, 32'h5566_7788, 32'h114, 4'hf, 32'h5566_7788, 1'b0);
    store_op("R3 half off0", 2'b01, 32'h114, 16'h0000, 32'h1234_abcd, 32'h114, 4'hc, 32'habcd_0000, 1'b0);
    load_op("R3 merge upper", 2'b10, 1'b0, 32'h114, 16'h0000, 32'h114, 32'habcd_7788, 1'b0);
    store_op("R3 half off2", 2'b01, 32'h114, 16'h0002, 32'h0000_eeee, 32'h116, 4'h3, 32'h0000_eeee, 1'b0);
    load_op("R3 merge lower", 2'b10, 1'b0, 32'h114, 16'h0000, 32'h114, 32'habcd_eeee, 1'b0);
  endtask

  task automatic t_bad_stores;
    store_op("R5 half odd",  2'b01, 32'h114, 16'h0003, 32'hffff_ffff, 32'h117, 4'h0, 32'h0, 1'b1);
    store_op("R5 word off1", 2'b10, 32'h114, 16'h0001, 32'hffff_ffff, 32'h115, 4'h0, 32'h0, 1'b1);
    store_op("R5 rsvd size", 2'b11, 32'h114, 16'h0000, 32'hffff_ffff, 32'h114, 4'h0, 32'h0, 1'b1);
    load_op("R5 word untouched", 2'b10, 1'b0, 32'h114, 16'h0000, 32'h114, 32'habcd_eeee, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1; req_size = 2'b10;
    base_val = 32'h114; store_val = 32'h0; insn = '0;
    @(negedge clk);
    check("R12 idle mask", {28'h0, bus_wmask}, 32'h0);
    check("R12 idle rd",   {30'h0, bus_rd, st_fault}, 32'h0);
    req_store = 1'b0;
    @(negedge clk);
    check("R12 idle no result", {31'h0, ld_valid}, 32'h0);
    load_op("R12 word kept", 2'b10, 1'b0, 32'h114, 16'h0000, 32'h114, 32'habcd_eeee, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_word_and_addr();
    t_byte_loads();
    t_half_word_loads();
    t_bad_loads();
    t_byte_stores();
    t_half_stores();
    t_bad_stores();
    t_idle();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule